// File: doc/BRIEF.md
# Spike Vector Index Serializer

Once per time step a wide spike vector, one bit per pre-synaptic neuron, is loaded into this block. It then emits the position of every set bit as a binary index, lowest position first, at a rate of one index per clock. Each index can be used as the shared read address of a weight memory, so only neurons that actually spiked produce work downstream. Clear bits cost no cycles.

The same block also serves on the output side. Each emitted index is paired with a 9-bit source node address that is captured at load, giving an address-event word ready for the network. The block finds the lowest set bit as a one-hot value, encodes it to a binary index, and removes that bit from a working copy with an XOR once the consumer takes it. A one-cycle done pulse marks the end of each vector.

Top module: `spike_index_serializer`

## Requirements
- R1: While reset is held, and after reset until the first load, `idx_valid_o` and `done_o` are both 0.
- R2: For a loaded vector, the block emits the index i exactly once for every set bit i of `vec_i`, in strictly ascending order. It emits no index for a clear bit.
- R3: The first index is valid in the cycle after the load edge. With `idx_ready_i` held high, one index is accepted on every clock edge.
- R4: While `idx_valid_o` is 1 and `idx_ready_i` is 0, the index and the event word stay unchanged and valid in the next cycle.
- R5: `done_o` is 1 for exactly one cycle: the cycle after the edge that accepts the last index. `idx_valid_o` is 0 in that cycle and stays 0 afterwards until the next load.
- R6: An all-zero vector emits no index and raises `done_o` in the cycle after its load.
- R7: `load_i` is ignored while a vector is being walked, including the done cycle. It neither changes the emitted sequence nor starts a new walk.
- R8: `evt_o` equals {source node, index}. Bits [7:0] hold the index, [10:8] hold X, [13:11] hold Y and [16:14] hold Z. The source node is the value of `src_node_i` captured at load (X in bits [2:0], Y in [5:3], Z in [8:6]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load strobe for a new spike vector; taken only when idle |
| vec_i | input | 256 | Spike vector, bit i set when neuron i spiked |
| src_node_i | input | 9 | Source node address {Z,Y,X}, 3 bits each |
| idx_valid_o | output | 1 | An index is offered |
| idx_ready_i | input | 1 | Consumer accepts the offered index |
| idx_o | output | 8 | Position of the lowest remaining set bit |
| evt_o | output | 17 | Address-event word {node, index} |
| done_o | output | 1 | One-cycle pulse after the vector is exhausted |

## Verification
Several properties are checked on every cycle. The offered index must point at a bit that is still set, the index and event word must hold while the consumer stalls, and accepted indices must rise strictly. Done must not coincide with a valid index and must not last beyond one cycle, and an empty load must be followed by done. Only the bench scenarios can show that the emitted set matches the loaded vector exactly and that the event word carries the node captured at load. The same holds for loads that arrive mid-walk or in the done cycle, which must leave the output sequence untouched.

// File: rtl/spk_ser_pkg.sv
// Shared types for the spike index serializer.
// Assumes a node address of three equal coordinate fields, X lowest.
package spk_ser_pkg;
    localparam int COORD_W = 3;
    localparam int NODE_W  = 3 * COORD_W;

    typedef struct packed {
        logic [COORD_W-1:0] z;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } node_addr_t;
endpackage

// File: rtl/spk_lowbit_isolate.sv
// Isolates the lowest set bit of a vector as a one-hot value.
// Assumes nothing about the input; an all-zero input gives all zero.
module spk_lowbit_isolate #(
    parameter int W = 256
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] onehot_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Two's-complement trick: v AND (-v) keeps only the lowest one.
    always_comb onehot_o = vec_i & (~vec_i + ONE);
endmodule

// File: rtl/spk_onehot_encode.sv
// Converts a one-hot vector into the binary position of its set bit.
// Assumes at most one bit is set; zero input yields index zero.
module spk_onehot_encode #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  onehot_i,
    output logic [IW-1:0] idx_o
);
    // OR together the positions of all set bits (only one is set).
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot_i[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/spk_event_pack.sv
// Builds an address-event word from a node address and a neuron index.
// Assumes the caller holds both inputs stable while the word is used.
// With EVT_EN = 0 the word is tied to zero and the packer costs nothing.
module spk_event_pack
    import spk_ser_pkg::*;
#(
    parameter int IW     = 8,
    parameter bit EVT_EN = 1'b1
) (
    input  node_addr_t           node_i,
    input  logic [IW-1:0]        idx_i,
    output logic [NODE_W+IW-1:0] evt_o
);
    generate
        if (EVT_EN) begin : g_pack
            // Node in the upper bits, neuron index in the lower bits.
            always_comb evt_o = {node_i, idx_i};
        end else begin : g_none
            // Event output not built.
            always_comb evt_o = '0;
        end
    endgenerate
endmodule

// File: rtl/spike_index_serializer.sv
// Walks a loaded spike vector lowest bit first and emits one index per
// accepted handshake, together with an address-event word.
// Assumes the consumer obeys valid/ready: an offered index is consumed
// only on an edge where idx_ready_i is high. Loads are taken only when idle.
module spike_index_serializer
    import spk_ser_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter bit EVT_EN = 1'b1,
    localparam int IW    = $clog2(VEC_W),
    localparam int EW    = NODE_W + IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [NODE_W-1:0] src_node_i,
    output logic              idx_valid_o,
    input  logic              idx_ready_i,
    output logic [IW-1:0]     idx_o,
    output logic [EW-1:0]     evt_o,
    output logic              done_o
);
    logic [VEC_W-1:0] work_q;
    logic [VEC_W-1:0] pick;
    logic             busy_q;
    node_addr_t       node_q;
    logic             work_empty;

    spk_lowbit_isolate #(.W(VEC_W)) u_isolate (
        .vec_i    (work_q),
        .onehot_o (pick)
    );

    spk_onehot_encode #(.W(VEC_W), .IW(IW)) u_encode (
        .onehot_i (pick),
        .idx_o    (idx_o)
    );

    spk_event_pack #(.IW(IW), .EVT_EN(EVT_EN)) u_pack (
        .node_i (node_q),
        .idx_i  (idx_o),
        .evt_o  (evt_o)
    );

    // Flag an exhausted working vector.
    always_comb work_empty = ~|work_q;

    // Offer an index while bits remain; signal done once they are gone.
    always_comb begin
        idx_valid_o = busy_q & ~work_empty;
        done_o      = busy_q & work_empty;
    end

    // Load when idle, clear the emitted bit on handshake, return to idle after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            busy_q <= 1'b0;
            node_q <= '0;
        end else if (!busy_q) begin
            if (load_i) begin
                work_q <= vec_i;
                node_q <= node_addr_t'(src_node_i);
                busy_q <= 1'b1;
            end
        end else if (work_empty) begin
            busy_q <= 1'b0;
        end else if (idx_ready_i) begin
            work_q <= work_q ^ pick;
        end
    end

    AST_IDX_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid_o |-> work_q[idx_o]) else $error("index points at clear bit"); // R2
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid_o && idx_ready_i) |=> (!idx_valid_o || idx_o > $past(idx_o))) else $error("order broken"); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid_o && !idx_ready_i) |=> (idx_valid_o && $stable(idx_o) && $stable(evt_o))) else $error("stall not held"); // R4
    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !idx_valid_o) else $error("done with valid"); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !idx_valid_o)) else $error("done too long"); // R5
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_q && vec_i == '0) |=> done_o) else $error("empty load no done"); // R6
endmodule

// File: tb/test_spike_index_serializer.sv
`timescale 1ns/1ps
module test_spike_index_serializer;
    localparam int VW = 256;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [VW-1:0] vec_i = '0;
    logic [8:0]    src_node_i = '0;
    logic          idx_valid_o;
    logic          idx_ready_i = 1'b0;
    logic [IW-1:0] idx_o;
    logic [16:0]   evt_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    spike_index_serializer i_spike_index_serializer (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .vec_i(vec_i),
        .src_node_i(src_node_i), .idx_valid_o(idx_valid_o),
        .idx_ready_i(idx_ready_i), .idx_o(idx_o), .evt_o(evt_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [VW-1:0] v);
        for (int i = 0; i < VW; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [VW-1:0] rand_vec(input int density);
        logic [VW-1:0] v = '0;
        for (int i = 0; i < VW; i++) v[i] = (($urandom % 100) < density);
        return v;
    endfunction

    // Load a vector and walk it against the bench model.
    task automatic run_case(input logic [VW-1:0] v, input logic [8:0] node,
                            input int rdy_pct, input bit poke);
        logic [VW-1:0] exp_v = v;
        bit prev_stall = 1'b0;
        @(negedge clk);
        load_i = 1'b1; vec_i = v; src_node_i = node;
        @(posedge clk); #1;
        load_i = 1'b0; vec_i = ~v; src_node_i = ~node;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (exp_v == '0) begin
                chk(done_o == 1'b1, (v == '0) ? "R6 done after empty load" : "R5 done after last", done_o, 1);
                chk(idx_valid_o == 1'b0, "R5 no valid at done", idx_valid_o, 0);
                if (poke) begin load_i = 1'b1; vec_i = '1; end
                break;
            end
            begin
                int lo = lowest(exp_v);
                chk(idx_valid_o == 1'b1, "R3 valid while bits remain", idx_valid_o, 1);
                chk(idx_o == IW'(lo), prev_stall ? "R4 held index" : "R2 index order", idx_o, lo);
                chk(evt_o == {node, IW'(lo)}, "R8 event word", evt_o, {node, IW'(lo)});
                chk(done_o == 1'b0, "R5 no early done", done_o, 0);
                idx_ready_i = (($urandom % 100) < rdy_pct);
                if (poke && cyc == 2) begin load_i = 1'b1; vec_i = '1; src_node_i = 9'h1FF; end
                @(posedge clk); #1;
                load_i = 1'b0;
                prev_stall = !idx_ready_i;
                if (idx_ready_i) exp_v[lo] = 1'b0;
            end
        end
        @(posedge clk); #1;
        load_i = 1'b0; idx_ready_i = 1'b0;
        chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
        chk(idx_valid_o == 1'b0, "R7 idle after done, late load ignored", idx_valid_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Reset state
        repeat (3) @(posedge clk);
        #1;
        chk(idx_valid_o == 1'b0, "R1 valid in reset", idx_valid_o, 0);
        chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(idx_valid_o == 1'b0, "R1 valid after reset", idx_valid_o, 0);
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);

        // Directed corners
        run_case(VW'(4'b1010), 9'h0A5, 100, 1'b0);          // R2 indices 1 then 3
        run_case('0, 9'h111, 100, 1'b0);                     // R6 empty
        run_case('0, 9'h022, 100, 1'b1);                     // R7 load in done cycle
        run_case({1'b1, {(VW-1){1'b0}}}, 9'h1C3, 100, 1'b0); // top bit only
        run_case(VW'(1), 9'h007, 40, 1'b0);                  // bottom bit, stalls R4
        run_case('1, 9'h155, 100, 1'b0);                     // R3 full rate
        run_case(VW'(64'hF0F0_0000_0000_0F0F), 9'h0C8, 50, 1'b1); // R7 mid-walk load

        // Random vectors
        for (int n = 0; n < 30; n++) begin
            int dens = (n % 3 == 0) ? 5 : ((n % 3 == 1) ? 40 : 90);
            run_case(rand_vec(dens), 9'($urandom), 30 + int'($urandom % 71), (n % 4) == 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule